// File: doc/BRIEF.md
# Dual retriggerable down-counter timer

This block holds two independent 8-bit down-counting timers, T0 and T1, behind a small register-mapped bus. Each timer has a stored initial count, a stored initial prescaler value, a working prescaler and a working counter. Software writes the initial values, then uses a shared mode register to enable counting, stop it, or load the working counters from the stored values. A load is requested by writing 1 to a per-timer load bit. That bit clears itself on the next clock, and the requested transfer happens on that clock. A load works as a retrigger on a timer that is already running.

While a timer is enabled, its prescaler counts down once per clock. Each time the prescaler wraps, the working counter steps down by one. When the counter steps from 1 to its terminal point, the timer raises a one-cycle terminal-count pulse and reloads its initial values. A per-timer mode input then selects what follows. In continuous mode the timer keeps running. In single-pass mode it stops with its enable bit cleared. Reading a counter register returns the live count, while writing it changes only the stored reload value.

Top module: `dual_dntimer`

## Requirements
- R1: After reset, both enable bits, both load bits, the stored values and all working counters are 0, so every register reads 00h.
- R2: The mode register sits at address F1h. Bit 0 requests a load of T0, bit 1 enables T0, bit 2 requests a load of T1 and bit 3 enables T1. Writing 1 to a load bit copies that timer's stored prescaler and count values into its working prescaler and counter on the following clock. Writing 0 to a load bit has no effect.
- R3: A load bit clears itself one clock after it is set. A read of the mode register returns 0 in bits 0, 2 and 7..4, and returns the enable bits in bits 1 and 3.
- R4: The T0 counter register is at F4h and the T1 counter register is at F2h. A write stores the reload value and leaves the live count unchanged. A read returns the live count.
- R5: The T0 prescaler register is at F5h and the T1 prescaler register is at F3h. The stored 6-bit value reads back zero-extended. A value of 0 gives a prescale of 64 clocks, and any other value P gives P clocks.
- R6: While a timer is enabled, its counter decrements once every P clocks. While it is disabled, it holds its count.
- R7: A stored count of 00h stands for 256, so the counter passes through FFh after 00h.
- R8: A load on a running timer restarts it from the stored values, and the timer keeps running.
- R9: When the counter steps from 1, tc_pulse for that timer is high for one cycle and the counter reloads its stored count. In continuous mode (cont_mode bit = 1), counting then goes on.
- R10: In single-pass mode (cont_mode bit = 0), the terminal step also clears the timer's enable bit, and the timer stops at its reloaded count.
- R11: When a pending load and a count step fall on the same clock, the load wins: no step and no terminal pulse happen on that clock.
- R12: The two timers count independently and do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one write per clock in which it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| cont_mode | input | 2 | Per-timer mode: 1 = continuous, 0 = single pass |
| tc_pulse | output | 2 | Per-timer one-cycle terminal-count pulse |

## Verification
The hardest case to create from the ports is a retrigger whose transfer clock coincides with the counter step from 1. On that clock, the load has to suppress both the step and the terminal pulse. The stimulus runs T0 with a prescale of 1 and times a mode write by cycle count so that the pending load lands on exactly that edge. The scoreboard then treats any pulse at that cycle as unexpected, and checks that the next pulse comes a full period after the reload. The 256-count case is reached with a prescale of 1 on T1, followed by a single-pass stop.

// File: rtl/dntmr_pkg.sv
`timescale 1ns/1ps
package dntmr_pkg;
    localparam int ADDR_W  = 8;
    localparam int NUM_TMR = 2;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t MODE_ADDR = 8'hF1;

    // Counter register address per timer
    function automatic addr_t cnt_addr(input int idx);
        return (idx == 0) ? 8'hF4 : 8'hF2;
    endfunction

    // Prescaler register address per timer
    function automatic addr_t pre_addr(input int idx);
        return (idx == 0) ? 8'hF5 : 8'hF3;
    endfunction

    typedef struct packed {
        logic               is_mode;
        logic [NUM_TMR-1:0] is_cnt;
        logic [NUM_TMR-1:0] is_pre;
    } dec_t;
endpackage

// File: rtl/dntmr_chan.sv
`timescale 1ns/1ps
module dntmr_chan #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic             pre_we,
    input  logic             mode_we,
    input  logic             ld_bit,
    input  logic             en_bit,
    input  logic [CNT_W-1:0] wdata,
    input  logic             cont,
    output logic [CNT_W-1:0] live_cnt,
    output logic [PRE_W-1:0] init_pre,
    output logic             en_o,
    output logic             ld_o,
    output logic             tc_o
);
    typedef struct packed {
        logic [CNT_W-1:0] init_cnt;
        logic [PRE_W-1:0] init_pre;
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
        logic             en;
        logic             ld;
        logic             tc;
    } chan_t;

    chan_t st_d, st_q;
    logic  pre_wrap;

    always_comb begin
        st_d     = st_q;
        st_d.tc  = 1'b0;
        pre_wrap = (st_q.pre == PRE_W'(1));

        if (cnt_we) st_d.init_cnt = wdata;
        if (pre_we) st_d.init_pre = wdata[PRE_W-1:0];

        if (st_q.ld) begin
            // pending load takes priority over a count step
            st_d.cnt = st_q.init_cnt;
            st_d.pre = st_q.init_pre;
            st_d.ld  = 1'b0;
        end else if (st_q.en) begin
            if (pre_wrap) begin
                st_d.pre = st_q.init_pre;
                if (st_q.cnt == CNT_W'(1)) begin
                    st_d.tc  = 1'b1;
                    st_d.cnt = st_q.init_cnt;
                    if (!cont) st_d.en = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end else begin
                st_d.pre = st_q.pre - PRE_W'(1);
            end
        end

        if (mode_we) begin
            st_d.en = en_bit;
            if (ld_bit) st_d.ld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_cnt = st_q.cnt;
    assign init_pre = st_q.init_pre;
    assign en_o     = st_q.en;
    assign ld_o     = st_q.ld;
    assign tc_o     = st_q.tc;
endmodule

// File: rtl/dntmr_dec.sv
`timescale 1ns/1ps
module dntmr_dec
    import dntmr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 6
) (
    input  addr_t                           bus_addr,
    input  logic                            bus_wr,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]   live_cnt,
    input  logic [NUM_TMR-1:0][PRE_W-1:0]   init_pre,
    input  logic [NUM_TMR-1:0]              en_vec,
    output logic                            mode_we,
    output logic [NUM_TMR-1:0]              cnt_we,
    output logic [NUM_TMR-1:0]              pre_we,
    output logic [CNT_W-1:0]                bus_rdata
);
    dec_t hit;

    always_comb begin
        hit.is_mode = (bus_addr == MODE_ADDR);
        for (int i = 0; i < NUM_TMR; i++) begin
            hit.is_cnt[i] = (bus_addr == cnt_addr(i));
            hit.is_pre[i] = (bus_addr == pre_addr(i));
        end
    end

    assign mode_we = bus_wr & hit.is_mode;
    assign cnt_we  = {NUM_TMR{bus_wr}} & hit.is_cnt;
    assign pre_we  = {NUM_TMR{bus_wr}} & hit.is_pre;

    always_comb begin
        bus_rdata = '0;
        if (hit.is_mode) begin
            for (int i = 0; i < NUM_TMR; i++) bus_rdata[2*i+1] = en_vec[i];
        end
        for (int i = 0; i < NUM_TMR; i++) begin
            if (hit.is_cnt[i]) bus_rdata = live_cnt[i];
            if (hit.is_pre[i]) bus_rdata = CNT_W'(init_pre[i]);
        end
    end
endmodule

// File: rtl/dual_dntimer.sv
`timescale 1ns/1ps
module dual_dntimer
    import dntmr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    input  logic [NUM_TMR-1:0] cont_mode,
    output logic [NUM_TMR-1:0] tc_pulse
);
    logic                          mode_we;
    logic [NUM_TMR-1:0]            cnt_we;
    logic [NUM_TMR-1:0]            pre_we;
    logic [NUM_TMR-1:0]            ld_vec;
    logic [NUM_TMR-1:0]            en_vec;
    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_vec;
    logic [NUM_TMR-1:0][PRE_W-1:0] pre_vec;

    dntmr_dec #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_dec (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .live_cnt  (cnt_vec),
        .init_pre  (pre_vec),
        .en_vec    (en_vec),
        .mode_we   (mode_we),
        .cnt_we    (cnt_we),
        .pre_we    (pre_we),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        dntmr_chan #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_we   (cnt_we[g]),
            .pre_we   (pre_we[g]),
            .mode_we  (mode_we),
            .ld_bit   (bus_wdata[2*g]),
            .en_bit   (bus_wdata[2*g+1]),
            .wdata    (bus_wdata),
            .cont     (cont_mode[g]),
            .live_cnt (cnt_vec[g]),
            .init_pre (pre_vec[g]),
            .en_o     (en_vec[g]),
            .ld_o     (ld_vec[g]),
            .tc_o     (tc_pulse[g])
        );
    end
endmodule

// File: rtl/dntmr_chk.sv
`timescale 1ns/1ps
module dntmr_chk
    import dntmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input addr_t                         bus_addr,
    input logic                          bus_wr,
    input logic [3:0]                    wd_lo,
    input logic [CNT_W-1:0]              bus_rdata,
    input logic [NUM_TMR-1:0]            cont_mode,
    input logic [NUM_TMR-1:0]            tc_pulse,
    input logic [NUM_TMR-1:0]            ld_vec,
    input logic [NUM_TMR-1:0]            en_vec,
    input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_vec
);
    logic mode_wr;
    assign mode_wr = bus_wr && (bus_addr == MODE_ADDR);

    assert_mode_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == MODE_ADDR) |->
            (bus_rdata[0] == 1'b0 && bus_rdata[2] == 1'b0 && bus_rdata[CNT_W-1:4] == '0));

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
        assert_load_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_wr && wd_lo[2*g]) |=> ld_vec[g]);

        assert_load_self_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_vec[g] && !(mode_wr && wd_lo[2*g])) |=> !ld_vec[g]);

        assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_vec[g] && !ld_vec[g]) |=> $stable(cnt_vec[g]));

        assert_tc_from_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
            tc_pulse[g] |-> ($past(cnt_vec[g]) == CNT_W'(1)));

        assert_single_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (tc_pulse[g] && !cont_mode[g] && !$past(mode_wr)) |-> !en_vec[g]);

        assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ld_vec[g] |=> !tc_pulse[g]);
    end
endmodule

bind dual_dntimer dntmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .wd_lo     (bus_wdata[3:0]),
    .bus_rdata (bus_rdata),
    .cont_mode (cont_mode),
    .tc_pulse  (tc_pulse),
    .ld_vec    (ld_vec),
    .en_vec    (en_vec),
    .cnt_vec   (cnt_vec)
);

// File: tb/sim_dual_dntimer.sv
`timescale 1ns/1ps
module sim_dual_dntimer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [1:0] cont = 2'b01;
    logic [1:0] tc;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    int q0[$];
    int q1[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_dntimer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .cont_mode(cont), .tc_pulse(tc)
    );

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            failures++;
            $display("FAIL %s addr=%h got=%h exp=%h cyc=%0d", req, a, rdata, exp, cyc);
        end
    endtask

    task automatic wait_negs(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor: pop expected terminal-count cycles and compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (tc[0]) begin
                checks++;
                if (q0.size() == 0) begin
                    failures++;
                    $display("FAIL R9 T0 pulse got=cyc%0d exp=none", cyc);
                end else begin
                    int e;
                    e = q0.pop_front();
                    if (e != cyc) begin
                        failures++;
                        $display("FAIL R9 T0 pulse got=cyc%0d exp=cyc%0d", cyc, e);
                    end
                end
            end
            if (tc[1]) begin
                checks++;
                if (q1.size() == 0) begin
                    failures++;
                    $display("FAIL R9 T1 pulse got=cyc%0d exp=none", cyc);
                end else begin
                    int e;
                    e = q1.pop_front();
                    if (e != cyc) begin
                        failures++;
                        $display("FAIL R9 T1 pulse got=cyc%0d exp=cyc%0d", cyc, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=cyc%0d exp=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c0;
        wait_negs(3);
        // R1: reset state
        read_chk(8'hF1, 8'h00, "R1");
        read_chk(8'hF4, 8'h00, "R1");
        read_chk(8'hF2, 8'h00, "R1");
        read_chk(8'hF5, 8'h00, "R1");
        read_chk(8'hF3, 8'h00, "R1");
        rst_n = 1'b1;
        wait_negs(2);

        // R2 / R4 / R5: stored values, load without enable
        bus_write(8'hF4, 8'h03);
        bus_write(8'hF5, 8'h02);
        bus_write(8'hF1, 8'h01);
        read_chk(8'hF4, 8'h00, "R4");
        @(negedge clk);
        read_chk(8'hF4, 8'h03, "R2");
        read_chk(8'hF1, 8'h00, "R3");
        read_chk(8'hF5, 8'h02, "R5");
        bus_write(8'hF4, 8'h09);
        bus_write(8'hF1, 8'h00);
        wait_negs(2);
        read_chk(8'hF4, 8'h03, "R2");

        // R6 / R9: continuous T0, count 3, prescale 2
        bus_write(8'hF4, 8'h03);
        bus_write(8'hF1, 8'h03);
        c0 = cyc;
        q0.push_back(c0 + 7); q0.push_back(c0 + 13); q0.push_back(c0 + 19);
        read_chk(8'hF1, 8'h02, "R3");
        wait_negs(3);
        read_chk(8'hF4, 8'h02, "R6");
        wait_negs(2);
        read_chk(8'hF4, 8'h01, "R6");
        wait_until(c0 + 20);
        bus_write(8'hF1, 8'h00);
        read_chk(8'hF4, 8'h02, "R6");
        wait_negs(3);
        read_chk(8'hF4, 8'h02, "R6");

        // R5: prescale 0 means 64
        bus_write(8'hF5, 8'h00);
        bus_write(8'hF4, 8'h01);
        bus_write(8'hF1, 8'h03);
        c0 = cyc;
        q0.push_back(c0 + 65);
        wait_until(c0 + 66);
        bus_write(8'hF1, 8'h00);

        // R8 / R11: retrigger on running T0 at the terminal step
        bus_write(8'hF5, 8'h01);
        bus_write(8'hF4, 8'h04);
        bus_write(8'hF1, 8'h03);
        c0 = cyc;
        wait_negs(2);
        read_chk(8'hF4, 8'h03, "R6");
        bus_write(8'hF1, 8'h03);
        c0 = cyc;
        q0.push_back(c0 + 5); q0.push_back(c0 + 9);
        @(negedge clk);
        read_chk(8'hF4, 8'h04, "R8 R11");
        read_chk(8'hF1, 8'h02, "R8");
        wait_until(c0 + 10);
        bus_write(8'hF1, 8'h00);

        // R7 / R10: T1 single pass, count 00h = 256, prescale 1
        cont = 2'b01;
        bus_write(8'hF2, 8'h00);
        bus_write(8'hF3, 8'h01);
        bus_write(8'hF1, 8'h0C);
        c0 = cyc;
        q1.push_back(c0 + 257);
        wait_negs(2);
        read_chk(8'hF2, 8'hFF, "R7");
        read_chk(8'hF1, 8'h08, "R10");
        wait_until(c0 + 260);
        read_chk(8'hF1, 8'h00, "R10");
        read_chk(8'hF2, 8'h00, "R10");
        wait_negs(3);
        read_chk(8'hF2, 8'h00, "R10");

        // R12: both timers together
        cont = 2'b11;
        bus_write(8'hF4, 8'h02);
        bus_write(8'hF5, 8'h03);
        bus_write(8'hF2, 8'h05);
        bus_write(8'hF3, 8'h01);
        bus_write(8'hF1, 8'h0F);
        c0 = cyc;
        q0.push_back(c0 + 7); q0.push_back(c0 + 13);
        q1.push_back(c0 + 6); q1.push_back(c0 + 11);
        read_chk(8'hF1, 8'h0A, "R12");
        wait_until(c0 + 13);
        bus_write(8'hF1, 8'h00);
        read_chk(8'hF1, 8'h00, "R12");
        read_chk(8'hF3, 8'h01, "R12");

        wait_negs(5);
        checks++;
        if (q0.size() != 0 || q1.size() != 0) begin
            failures++;
            $display("FAIL R9 missing pulses got=%0d,%0d pending exp=0,0", q0.size(), q1.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule